// File: doc/BRIEF.md
# Deferred Store Buffer with Load Forwarding

This block sits after the tag-check stage of a pipelined data cache and in front of the cache data array. A store whose tag check reports a hit is not written into the array straight away. Its address and data are parked in a small first-in first-out buffer. A store that misses is dropped. Parked entries are copied into the array later, one per cycle, in any cycle in which the single array port is not needed by a load. A cycle that carries a new store can also drain an entry, so a store never needs a second array access of its own.

A load looks at the buffer and the array in the same cycle. If one or more parked entries hold the load address, the value from the most recently parked one is returned. Otherwise the array word is returned. The result appears one cycle after the load is presented.

The block also produces the pipeline stall that keeps the buffer from overflowing. A parameter picks one of two rules. The exact rule adds the occupied entries to the stores still travelling down the pipeline. The simple rule only looks at whether a store is in decode and how full the buffer is. The cache array is a behavioural model that resets to zero.

Top module: `stbuf_top`

## Requirements
- R1: After reset the buffer is empty, every array word reads as zero, `ld_valid_o` is low and (exact rule, no stores in flight) `stall_o` is low.
- R2: A store presented with `st_valid_i` and `st_hit_i` both high is parked. A load of the same address in a later cycle returns its data, whether the entry is still parked or already drained.
- R3: A store presented with `st_hit_i` low leaves both the buffer occupancy and the array unchanged. A later load of its address returns the older value.
- R4: When several parked entries hold the load address, the load returns the data of the one parked last.
- R5: In a cycle with `ld_valid_i` low and a non-empty buffer, exactly one entry, the oldest, is written into the array. If a hit store arrives in the same cycle, the occupancy is unchanged, even when the buffer is full.
- R6: In a cycle with `ld_valid_i` high, no entry is drained.
- R7: With `STALL_MODE` = exact, `stall_o` is high exactly when occupancy + `pipe_stores_i` + `dec_store_i` > `DEPTH`.
- R8: With `STALL_MODE` = simple, `stall_o` is high exactly when `dec_store_i` is high and occupancy ≥ `DEPTH` − 2.
- R9: A load whose address matches no parked entry returns the array word at that address.
- R10: Entries drain in parking order. After two stores to one address have both drained, the array holds the data of the second.
- R11: For a load presented in one cycle, `ld_valid_o` is high in the next cycle with the result on `ld_data_o`. In every other cycle `ld_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| st_valid_i | input | 1 | A store leaves tag check this cycle |
| st_hit_i | input | 1 | Tag-check outcome of that store (1 = hit) |
| st_addr_i | input | ADDR_W | Store word address |
| st_data_i | input | DATA_W | Store data |
| ld_valid_i | input | 1 | A load uses the array port this cycle |
| ld_addr_i | input | ADDR_W | Load word address |
| ld_valid_o | output | 1 | Load result valid (one cycle after the load) |
| ld_data_o | output | DATA_W | Load result |
| dec_store_i | input | 1 | The instruction in decode is a store |
| pipe_stores_i | input | PIPE_W | Stores between decode and this block |
| stall_o | output | 1 | Hold the pipeline front end |

## Verification
The hardest thing to observe from the ports is where a value comes from: a forwarded buffer entry and an already drained word return the same data. Occupancy is not an output. The bench therefore keeps a load on the port in every cycle in which entries must stay parked. Between edges it reads the occupancy back through the exact stall rule by sweeping `pipe_stores_i` to the boundary. This makes it possible to confirm that a missed store was not queued, that loads block draining, and that a store into a full buffer is absorbed by a drain in the same cycle.

// File: rtl/stbuf_pkg.sv
package stbuf_pkg;

    // Rule used to raise the front-end stall.
    typedef enum logic {
        STALL_EXACT  = 1'b0,   // occupancy + stores in flight > depth
        STALL_SIMPLE = 1'b1    // store in decode and occupancy >= depth - 2
    } stall_mode_e;

endpackage

// File: rtl/stbuf_fifo.sv
// Circular store buffer with a newest-first associative lookup.
module stbuf_fifo #(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [ADDR_W-1:0] push_addr_i,
    input  logic [DATA_W-1:0] push_data_i,
    input  logic              pop_i,
    input  logic [ADDR_W-1:0] look_addr_i,
    output logic [ADDR_W-1:0] head_addr_o,
    output logic [DATA_W-1:0] head_data_o,
    output logic [CNT_W-1:0]  count_o,
    output logic              look_hit_o,
    output logic [DATA_W-1:0] look_data_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][ADDR_W-1:0] addr;
        logic [DEPTH-1:0][DATA_W-1:0] data;
        logic [PTR_W-1:0]             wr;
        logic [PTR_W-1:0]             rd;
        logic [CNT_W-1:0]             cnt;
    } fifo_state_t;

    fifo_state_t st_d, st_q;
    logic        do_pop, do_push;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d    = st_q;
        do_pop  = pop_i && (st_q.cnt != '0);
        do_push = push_i && ((st_q.cnt != CNT_W'(DEPTH)) || do_pop);

        if (do_push) begin
            st_d.addr[st_q.wr] = push_addr_i;
            st_d.data[st_q.wr] = push_data_i;
            st_d.wr            = bump(st_q.wr);
        end
        if (do_pop) begin
            st_d.rd = bump(st_q.rd);
        end
        if (do_push && !do_pop) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end else if (!do_push && do_pop) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Walk from oldest to newest; a later match overrides an earlier one.
    always_comb begin
        look_hit_o  = 1'b0;
        look_data_o = '0;
        for (int k = 0; k < DEPTH; k++) begin
            int idx;
            idx = int'(st_q.rd) + k;
            if (idx >= DEPTH) begin
                idx = idx - DEPTH;
            end
            if ((k < int'(st_q.cnt)) && (st_q.addr[idx] == look_addr_i)) begin
                look_hit_o  = 1'b1;
                look_data_o = st_q.data[idx];
            end
        end
    end

    assign head_addr_o = st_q.addr[st_q.rd];
    assign head_data_o = st_q.data[st_q.rd];
    assign count_o     = st_q.cnt;

endmodule

// File: rtl/stbuf_array.sv
// Behavioural single-port data array: one registered read or one write per cycle.
module stbuf_array #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              re_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int WORDS = 1 << ADDR_W;

    typedef struct packed {
        logic [WORDS-1:0][DATA_W-1:0] mem;
        logic [DATA_W-1:0]            rdata;
    } arr_state_t;

    arr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we_i) begin
            st_d.mem[waddr_i] = wdata_i;
        end
        if (re_i) begin
            st_d.rdata = st_q.mem[raddr_i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata_o = st_q.rdata;

endmodule

// File: rtl/stbuf_stall.sv
// Front-end stall generator; the parameter selects the rule.
module stbuf_stall
    import stbuf_pkg::*;
#(
    parameter int          DEPTH      = 4,
    parameter stall_mode_e STALL_MODE = STALL_EXACT,
    parameter int          CNT_W      = $clog2(DEPTH + 1),
    parameter int          PIPE_W     = $clog2(DEPTH + 1) + 1
) (
    input  logic [CNT_W-1:0]  occ_i,
    input  logic [PIPE_W-1:0] pipe_i,
    input  logic              dec_i,
    output logic              stall_o
);
    localparam int SUM_W = ((CNT_W > PIPE_W) ? CNT_W : PIPE_W) + 2;

    logic [SUM_W-1:0] total;
    logic             exact_w, simple_w;

    always_comb begin
        total    = SUM_W'(occ_i) + SUM_W'(pipe_i) + SUM_W'(dec_i);
        exact_w  = total > SUM_W'(DEPTH);
        simple_w = dec_i && (int'(occ_i) >= DEPTH - 2);
        stall_o  = (STALL_MODE == STALL_SIMPLE) ? simple_w : exact_w;
    end

endmodule

// File: rtl/stbuf_top.sv
module stbuf_top
    import stbuf_pkg::*;
#(
    parameter int          DEPTH      = 4,
    parameter int          ADDR_W     = 6,
    parameter int          DATA_W     = 32,
    parameter stall_mode_e STALL_MODE = STALL_EXACT,
    parameter int          PIPE_W     = $clog2(DEPTH + 1) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_valid_i,
    input  logic              st_hit_i,
    input  logic [ADDR_W-1:0] st_addr_i,
    input  logic [DATA_W-1:0] st_data_i,
    input  logic              ld_valid_i,
    input  logic [ADDR_W-1:0] ld_addr_i,
    output logic              ld_valid_o,
    output logic [DATA_W-1:0] ld_data_o,
    input  logic              dec_store_i,
    input  logic [PIPE_W-1:0] pipe_stores_i,
    output logic              stall_o
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic              ld_v;
        logic              fwd_hit;
        logic [DATA_W-1:0] fwd_data;
    } top_state_t;

    top_state_t        st_d, st_q;
    logic              enq_w, drain_w;
    logic [CNT_W-1:0]  occ_w;
    logic [ADDR_W-1:0] head_addr;
    logic [DATA_W-1:0] head_data;
    logic              look_hit;
    logic [DATA_W-1:0] look_data;
    logic [DATA_W-1:0] arr_rdata;

    // Hit stores are parked; the array port drains only when no load owns it.
    assign enq_w   = st_valid_i && st_hit_i;
    assign drain_w = !ld_valid_i && (occ_w != '0);

    stbuf_fifo #(
        .DEPTH (DEPTH),
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .CNT_W (CNT_W)
    ) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (enq_w),
        .push_addr_i(st_addr_i),
        .push_data_i(st_data_i),
        .pop_i      (drain_w),
        .look_addr_i(ld_addr_i),
        .head_addr_o(head_addr),
        .head_data_o(head_data),
        .count_o    (occ_w),
        .look_hit_o (look_hit),
        .look_data_o(look_data)
    );

    stbuf_array #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_array (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (drain_w),
        .waddr_i(head_addr),
        .wdata_i(head_data),
        .re_i   (ld_valid_i),
        .raddr_i(ld_addr_i),
        .rdata_o(arr_rdata)
    );

    stbuf_stall #(
        .DEPTH     (DEPTH),
        .STALL_MODE(STALL_MODE),
        .CNT_W     (CNT_W),
        .PIPE_W    (PIPE_W)
    ) u_stall (
        .occ_i  (occ_w),
        .pipe_i (pipe_stores_i),
        .dec_i  (dec_store_i),
        .stall_o(stall_o)
    );

    always_comb begin
        st_d          = st_q;
        st_d.ld_v     = ld_valid_i;
        st_d.fwd_hit  = ld_valid_i && look_hit;
        st_d.fwd_data = look_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ld_valid_o = st_q.ld_v;
    assign ld_data_o  = !st_q.ld_v ? '0 : (st_q.fwd_hit ? st_q.fwd_data : arr_rdata);

endmodule

// File: rtl/stbuf_chk.sv
module stbuf_chk #(
    parameter int DEPTH = 4,
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             st_valid_i,
    input logic             st_hit_i,
    input logic             ld_valid_i,
    input logic             ld_valid_o,
    input logic [CNT_W-1:0] occ_w,
    input logic             drain_w
);

    // R1: reset empties the buffer and clears the load result
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (occ_w == '0 && !ld_valid_o));

    // R6: a load owns the array port, so nothing drains
    a_r6_load_holds_buffer: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid_i |-> !drain_w);

    // R5: an idle port with no new store lowers occupancy by one
    a_r5_idle_drains_one: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_valid_i && !(st_valid_i && st_hit_i) && occ_w != '0)
        |=> occ_w == $past(occ_w) - 1'b1);

    // R3: a missed store under a load leaves occupancy alone
    a_r3_miss_not_queued: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid_i && !st_hit_i && ld_valid_i) |=> occ_w == $past(occ_w));

    // R7: the stall must have kept a hit store out of a full, non-draining buffer
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid_i && st_hit_i && occ_w == CNT_W'(DEPTH)) |-> !ld_valid_i);

    // R11: a load is answered in the following cycle, and only then
    a_r11_load_answered: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid_i |=> ld_valid_o);

    a_r11_no_spurious_result: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_valid_i |=> !ld_valid_o);

endmodule

bind stbuf_top stbuf_chk #(
    .DEPTH(DEPTH),
    .CNT_W(CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .st_valid_i(st_valid_i),
    .st_hit_i  (st_hit_i),
    .ld_valid_i(ld_valid_i),
    .ld_valid_o(ld_valid_o),
    .occ_w     (occ_w),
    .drain_w   (drain_w)
);

// File: tb/stbuf_top_test.sv
`timescale 1ns/1ps
module stbuf_top_test;
    import stbuf_pkg::*;

    localparam int DEPTH  = 4;
    localparam int ADDR_W = 6;
    localparam int DATA_W = 32;
    localparam int PIPE_W = $clog2(DEPTH + 1) + 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              st_valid = 1'b0, st_hit = 1'b0;
    logic [ADDR_W-1:0] st_addr = '0, ld_addr = '0;
    logic [DATA_W-1:0] st_data = '0;
    logic              ld_valid = 1'b0;
    logic              dec_store = 1'b0;
    logic [PIPE_W-1:0] pipe_cnt = '0;
    logic              ld_vo, ld_vo2, stall, stall2;
    logic [DATA_W-1:0] ld_do, ld_do2;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [DATA_W-1:0] exp;
        string             req;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;   // 50 MHz

    stbuf_top #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
                .STALL_MODE(STALL_EXACT)) uut (
        .clk(clk), .rst_n(rst_n), .st_valid_i(st_valid), .st_hit_i(st_hit),
        .st_addr_i(st_addr), .st_data_i(st_data), .ld_valid_i(ld_valid),
        .ld_addr_i(ld_addr), .ld_valid_o(ld_vo), .ld_data_o(ld_do),
        .dec_store_i(dec_store), .pipe_stores_i(pipe_cnt), .stall_o(stall));

    stbuf_top #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
                .STALL_MODE(STALL_SIMPLE)) uut_simple (
        .clk(clk), .rst_n(rst_n), .st_valid_i(st_valid), .st_hit_i(st_hit),
        .st_addr_i(st_addr), .st_data_i(st_data), .ld_valid_i(ld_valid),
        .ld_addr_i(ld_addr), .ld_valid_o(ld_vo2), .ld_data_o(ld_do2),
        .dec_store_i(dec_store), .pipe_stores_i(pipe_cnt), .stall_o(stall2));

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Monitor: pops one expectation per load result.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (ld_vo) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R11 unexpected result", ld_do, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(ld_do == e.exp, e.req, ld_do, e.exp);
                end
            end
        end
    end

    // One cycle: drive at a falling edge, return at the next falling edge.
    task automatic step(input bit sv, input bit sh, input int sa, input int sd,
                        input bit lv, input int la, input int lexp, input string req);
        st_valid = sv; st_hit = sh;
        st_addr  = ADDR_W'(sa); st_data = DATA_W'(sd);
        ld_valid = lv; ld_addr = ADDR_W'(la);
        if (lv) begin
            exp_t e;
            e.exp = DATA_W'(lexp);
            e.req = req;
            sb.push_back(e);
        end
        @(posedge clk);
        @(negedge clk);
        st_valid = 1'b0; ld_valid = 1'b0;
    endtask

    // Occupancy read back through the exact stall rule, no clock edge.
    task automatic occ_is(input int k, input string req);
        dec_store = 1'b0;
        pipe_cnt  = PIPE_W'(DEPTH - k);
        #1 check(stall == 1'b0, req, stall, 0);
        pipe_cnt  = PIPE_W'(DEPTH - k + 1);
        #1 check(stall == 1'b1, req, stall, 1);
        pipe_cnt  = '0;
    endtask

    task automatic simple_is(input bit dec, input bit exp, input string req);
        dec_store = dec;
        #1 check(stall2 == exp, req, stall2, exp);
        dec_store = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check(ld_vo == 1'b0, "R1 ld_valid_o after reset", ld_vo, 0);
        #1 check(stall == 1'b0, "R1 stall after reset", stall, 0);
        occ_is(0, "R1 empty after reset");

        // R9: empty buffer, array reads zero
        step(0, 0, 0, 0, 1, 5, 0, "R9 load from reset array");

        // R2 / R6: park a store while loads hold the port
        step(1, 1, 3, 'h11, 1, 9, 0, "R9 unrelated load");
        step(0, 0, 0, 0, 1, 3, 'h11, "R2 forward parked store");
        occ_is(1, "R6 entry kept while loads run");
        simple_is(1, 0, "R8 simple rule below threshold");

        // R3: missed store is dropped
        step(1, 0, 7, 'hBAD, 1, 9, 0, "R9 unrelated load");
        step(0, 0, 0, 0, 1, 7, 0, "R3 missed store invisible");
        occ_is(1, "R3 missed store not queued");

        // R4: two more stores to address 3, newest wins
        step(1, 1, 3, 'h22, 1, 9, 0, "R9 unrelated load");
        simple_is(1, 1, "R8 simple rule at threshold");
        simple_is(0, 0, "R8 simple rule needs decode store");
        step(1, 1, 3, 'h33, 1, 9, 0, "R9 unrelated load");
        step(0, 0, 0, 0, 1, 3, 'h33, "R4 newest match");
        occ_is(3, "R7 exact rule at occupancy 3");
        dec_store = 1'b1; pipe_cnt = PIPE_W'(1);
        #1 check(stall == 1'b1, "R7 decode store counts", stall, 1);
        dec_store = 1'b0; pipe_cnt = '0;

        // R5 / R10: drain in order, one per idle cycle
        step(0, 0, 0, 0, 0, 0, 0, "");
        occ_is(2, "R5 one drained");
        step(0, 0, 0, 0, 0, 0, 0, "");
        step(0, 0, 0, 0, 0, 0, 0, "");
        occ_is(0, "R5 fully drained");
        step(0, 0, 0, 0, 1, 3, 'h33, "R10 last store lands in array");

        // Fill to capacity under loads
        for (int i = 0; i < DEPTH; i++) begin
            step(1, 1, 20 + i, 'hA0 + i, 1, 9, 0, "R9 unrelated load");
        end
        occ_is(DEPTH, "R7 full buffer stalls one more store");
        // Store into a full buffer on an idle port: drain and park together
        step(1, 1, 24, 'hA4, 0, 0, 0, "");
        occ_is(DEPTH, "R5 store absorbed by same-cycle drain");
        step(0, 0, 0, 0, 1, 20, 'hA0, "R2 drained store read from array");
        step(0, 0, 0, 0, 1, 24, 'hA4, "R2 parked store forwarded");
        for (int i = 0; i < DEPTH; i++) begin
            step(0, 0, 0, 0, 0, 0, 0, "");
        end
        occ_is(0, "R5 drained after full");
        step(0, 0, 0, 0, 1, 24, 'hA4, "R2 value after drain");
        step(0, 0, 0, 0, 1, 21, 'hA1, "R10 drained entry");
        step(0, 0, 0, 0, 0, 0, 0, "");
        check(ld_vo == 1'b0, "R11 no result without load", ld_vo, 0);
        check(sb.size() == 0, "R11 all loads answered", sb.size(), 0);

        done = 1'b1;
        finish_run();
    end

endmodule